// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block receives configuration words over a write-only three-wire serial link: a bus clock, a data line and an active-low frame strobe. All three wires are brought into the system clock domain through synchronisers. Edges are then found on the synchronised copies. While the strobe is low, every rising bus-clock edge shifts one data bit into a capture register, most significant bit first. When the strobe returns high, the captured frame is committed to one of two holding registers. The last bit of the frame, the address bit, picks the register.

The frame length is never checked. The capture register keeps only the most recent bits, so leading excess bits fall off the top. A short frame commits whatever older bits remain below the new ones. The channel word holds 23 bits of synthesizer and transmit settings. The trim word holds 11 bits of production trim and test selection. Every field is presented as a parallel output. The charge-pump code is also given as a signed step, and the two scale codes are also given as percentages.

The control state machine has three states. ST_IDLE waits for the strobe to fall and moves to ST_SHIFT, clearing the bit-seen flag. ST_SHIFT shifts on each bus-clock rise. When the strobe rises, ST_SHIFT goes to ST_COMMIT if at least one bit arrived, otherwise back to ST_IDLE. ST_COMMIT issues a one-cycle load and returns to ST_IDLE.

Top module: `tri_wire_cfg`

## Requirements
- R1: While the synchronised strobe is low, each rising bus-clock edge shifts the data line into the capture register, most significant bit first.
- R2: A rising strobe edge after at least one shifted bit loads the holding register chosen by the last bit received: 1 selects the channel word, 0 selects the trim word. The other word is left unchanged.
- R3: Only the most recent 24 bits (channel word) or 12 bits (trim word) form the frame. Excess leading bits are ignored. The capture register is not cleared between frames, so a short frame carries older bits in its upper positions.
- R4: The channel word bits, from the bit sent just before the address bit (bit 0) upward, are: charge-pump code [2:0], pretune [5:3], deviation code [8:6], compensation enable [9], Gaussian enable [10], fixed bits [12:11], VCO select [13] (1 = transmit), main code [15:14], swallow code [20:16], reference code [22:21].
- R5: The trim word bits are: test select [2:0], compensation scale code [5:3], demodulator trim [10:6].
- R6: cp_step equals the charge-pump code minus 4 as a signed value, so 000 gives -4 and 111 gives +3.
- R7: dev_pct and comp_pct equal 60 plus 10 times their 3-bit code, covering 60 to 130.
- R8: After reset, every field is zero except the charge-pump code, which is 100 (step 0).
- R9: A frame with no bus-clock pulse while the strobe is low leaves both words unchanged.
- R10: Bus-clock edges while the strobe is high do not alter the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bus clock |
| bus_data | input | 1 | Serial bus data |
| bus_en_n | input | 1 | Active-low frame strobe |
| ref_code | output | 2 | Reference divider code |
| swallow_code | output | 5 | Swallow counter code |
| main_code | output | 2 | Main counter code |
| vco_tx_sel | output | 1 | VCO select, 1 = transmit |
| fixed_bits | output | 2 | Fixed/test bits of the channel word |
| gauss_en | output | 1 | Gaussian filter enable |
| comp_en | output | 1 | Modulation compensation enable |
| dev_code | output | 3 | Deviation scale code |
| dev_pct | output | 8 | Deviation scale in percent |
| pretune_code | output | 3 | VCO pretune code |
| cp_code | output | 3 | Charge-pump current code |
| cp_step | output | 4 | Signed charge-pump step |
| demod_trim | output | 5 | Demodulator trim code |
| comp_code | output | 3 | Compensation scale code |
| comp_pct | output | 8 | Compensation scale in percent |
| test_sel | output | 3 | Test select code |

## Verification
The bench builds the port with its default parameters: two synchroniser stages and a 24-bit capture register. At these values, all eight codes of each 3-bit field can be swept on both words. The sweep alternates exact-length frames with frames that carry junk leading bits, and it checks that each word holds while the other is written. The bench also sends an empty frame and a single-bit frame sent after stray clock pulses. Because the capture register is small and keeps its contents between frames, the single-bit frame shows the shift-left carry from the previous frame directly at the outputs.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
    localparam int unsigned W1_DATA = 23;
    localparam int unsigned W2_DATA = 11;
    localparam int unsigned FRAME_W = W1_DATA + 1;

    typedef struct packed {
        logic [1:0] ref_code;
        logic [4:0] swallow;
        logic [1:0] main_code;
        logic       vco_tx;
        logic [1:0] fixed;
        logic       gauss_en;
        logic       comp_en;
        logic [2:0] dev;
        logic [2:0] pretune;
        logic [2:0] cp;
    } word1_t;

    typedef struct packed {
        logic [4:0] demod;
        logic [2:0] comp_scale;
        logic [2:0] test;
    } word2_t;

    localparam word1_t W1_RESET = '{cp: 3'b100, default: '0};

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_COMMIT} cap_state_t;

    function automatic logic signed [3:0] cp_offset(input logic [2:0] c);
        return $signed({1'b0, c}) - 4'sd4;
    endfunction

    function automatic logic [7:0] scale_pct(input logic [2:0] c);
        return 8'd60 + 8'd10 * {5'd0, c};
    endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LANES  = 3,
    parameter logic [LANES-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[l]}};
            else        chain <= {chain[STAGES-2:0], din[l]};
        end
        assign dout[l] = chain[STAGES-1];
    end
endmodule

// File: rtl/tw_capture.sv
module tw_capture
    import tw_cfg_pkg::*;
#(
    parameter int unsigned WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_clk,
    input  logic             s_data,
    input  logic             s_en_n,
    output logic [WIDTH-1:0] frame,
    output logic             load
);
    cap_state_t state, state_nx;
    logic prev_clk, prev_en;
    logic clk_rise, en_rise, got_bit;
    logic [WIDTH-1:0] sh;

    assign clk_rise = s_clk & ~prev_clk;
    assign en_rise  = s_en_n & ~prev_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk <= 1'b0;
            prev_en  <= 1'b1;
        end else begin
            prev_clk <= s_clk;
            prev_en  <= s_en_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!s_en_n) state_nx = ST_SHIFT;
            ST_SHIFT:  if (en_rise) state_nx = (got_bit || clk_rise) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        unique case (state)
            ST_COMMIT: load = 1'b1;
            default:   load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            got_bit <= 1'b0;
        end else begin
            if (state == ST_IDLE) got_bit <= 1'b0;
            if (state == ST_SHIFT && clk_rise) begin
                sh      <= {sh[WIDTH-2:0], s_data};
                got_bit <= 1'b1;
            end
        end
    end

    assign frame = sh;

    AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_rise |=> $stable(sh)); // R10
    AST_COMMIT_ON_ENRISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && en_rise && (got_bit || clk_rise)) |=> load); // R2
    AST_NO_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && en_rise && !got_bit && !clk_rise) |=> !load); // R9
endmodule

// File: rtl/tw_regs.sv
module tw_regs
    import tw_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output word1_t             w1,
    output word2_t             w2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w1 <= W1_RESET;
            w2 <= '0;
        end else if (load) begin
            if (frame[0]) w1 <= word1_t'(frame[W1_DATA:1]);
            else          w2 <= word2_t'(frame[W2_DATA:1]);
        end
    end

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($stable(w1) || $stable(w2))); // R2
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(w1) && $stable(w2))); // R9
endmodule

// File: rtl/tri_wire_cfg.sv
module tri_wire_cfg
    import tw_cfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_data,
    input  logic              bus_en_n,
    output logic [1:0]        ref_code,
    output logic [4:0]        swallow_code,
    output logic [1:0]        main_code,
    output logic              vco_tx_sel,
    output logic [1:0]        fixed_bits,
    output logic              gauss_en,
    output logic              comp_en,
    output logic [2:0]        dev_code,
    output logic [7:0]        dev_pct,
    output logic [2:0]        pretune_code,
    output logic [2:0]        cp_code,
    output logic signed [3:0] cp_step,
    output logic [4:0]        demod_trim,
    output logic [2:0]        comp_code,
    output logic [7:0]        comp_pct,
    output logic [2:0]        test_sel
);
    logic [2:0] s_bus;
    logic [FRAME_W-1:0] frame;
    logic load;
    word1_t w1;
    word2_t w2;

    tw_sync #(.STAGES(SYNC_STAGES), .LANES(3), .RESET_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({bus_en_n, bus_data, bus_clk}), .dout(s_bus)
    );

    tw_capture #(.WIDTH(FRAME_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .s_clk(s_bus[0]), .s_data(s_bus[1]), .s_en_n(s_bus[2]),
        .frame(frame), .load(load)
    );

    tw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .load(load), .frame(frame), .w1(w1), .w2(w2)
    );

    assign ref_code     = w1.ref_code;
    assign swallow_code = w1.swallow;
    assign main_code    = w1.main_code;
    assign vco_tx_sel   = w1.vco_tx;
    assign fixed_bits   = w1.fixed;
    assign gauss_en     = w1.gauss_en;
    assign comp_en      = w1.comp_en;
    assign dev_code     = w1.dev;
    assign pretune_code = w1.pretune;
    assign cp_code      = w1.cp;
    assign demod_trim   = w2.demod;
    assign comp_code    = w2.comp_scale;
    assign test_sel     = w2.test;
    assign cp_step      = cp_offset(w1.cp);
    assign dev_pct      = scale_pct(w1.dev);
    assign comp_pct     = scale_pct(w2.comp_scale);

    AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pct >= 8'd60 && dev_pct <= 8'd130 && comp_pct >= 8'd60 && comp_pct <= 8'd130); // R7
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_step >= -4'sd4 && cp_step <= 4'sd3); // R6
endmodule

// File: tb/tb_tri_wire_cfg.sv
module tb_tri_wire_cfg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_data = 1'b0, bus_en_n = 1'b1;
    logic [1:0] ref_code, main_code, fixed_bits;
    logic [4:0] swallow_code, demod_trim;
    logic vco_tx_sel, gauss_en, comp_en;
    logic [2:0] dev_code, pretune_code, cp_code, comp_code, test_sel;
    logic [7:0] dev_pct, comp_pct;
    logic signed [3:0] cp_step;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [23:0] m_sh = '0;
    logic [22:0] m_w1 = 23'h4;
    logic [10:0] m_w2 = '0;

    always #2 clk = ~clk;

    tri_wire_cfg dut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data), .bus_en_n(bus_en_n),
        .ref_code(ref_code), .swallow_code(swallow_code), .main_code(main_code),
        .vco_tx_sel(vco_tx_sel), .fixed_bits(fixed_bits), .gauss_en(gauss_en), .comp_en(comp_en),
        .dev_code(dev_code), .dev_pct(dev_pct), .pretune_code(pretune_code), .cp_code(cp_code),
        .cp_step(cp_step), .demod_trim(demod_trim), .comp_code(comp_code), .comp_pct(comp_pct),
        .test_sel(test_sel)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string name, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, name, got, exp);
        end
    endtask

    // frame: bits[n-1] sent first; model follows R1/R2/R3
    task automatic send(input logic [63:0] bits, input int n);
        bus_en_n = 1'b0;
        wait_cyc(8);
        for (int i = n - 1; i >= 0; i--) begin
            bus_data = bits[i];
            wait_cyc(4);
            bus_clk = 1'b1;
            wait_cyc(4);
            bus_clk = 1'b0;
            m_sh = {m_sh[22:0], bits[i]};
        end
        wait_cyc(4);
        bus_en_n = 1'b1;
        wait_cyc(12);
        if (n > 0) begin
            if (m_sh[0]) m_w1 = m_sh[23:1];
            else         m_w2 = m_sh[11:1];
        end
    endtask

    task automatic check_all(input string tag);
        // R4 field positions of the channel word
        check("R4", {tag, " cp"},      int'(cp_code),      int'(m_w1[2:0]));
        check("R4", {tag, " pretune"}, int'(pretune_code), int'(m_w1[5:3]));
        check("R4", {tag, " dev"},     int'(dev_code),     int'(m_w1[8:6]));
        check("R4", {tag, " compen"},  int'(comp_en),      int'(m_w1[9]));
        check("R4", {tag, " gauss"},   int'(gauss_en),     int'(m_w1[10]));
        check("R4", {tag, " fixed"},   int'(fixed_bits),   int'(m_w1[12:11]));
        check("R4", {tag, " vco"},     int'(vco_tx_sel),   int'(m_w1[13]));
        check("R4", {tag, " main"},    int'(main_code),    int'(m_w1[15:14]));
        check("R4", {tag, " swallow"}, int'(swallow_code), int'(m_w1[20:16]));
        check("R4", {tag, " ref"},     int'(ref_code),     int'(m_w1[22:21]));
        // R5 field positions of the trim word
        check("R5", {tag, " test"},    int'(test_sel),     int'(m_w2[2:0]));
        check("R5", {tag, " comp"},    int'(comp_code),    int'(m_w2[5:3]));
        check("R5", {tag, " demod"},   int'(demod_trim),   int'(m_w2[10:6]));
        check("R6", {tag, " step"},    int'(cp_step),      int'(m_w1[2:0]) - 4);
        check("R7", {tag, " devpct"},  int'(dev_pct),      60 + 10 * int'(m_w1[8:6]));
        check("R7", {tag, " comppct"}, int'(comp_pct),     60 + 10 * int'(m_w2[5:3]));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected completion", cyc);
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        // R8 reset values
        check("R8", "reset cp", int'(cp_code), 4);
        check("R8", "reset step", int'(cp_step), 0);
        check_all("R8 reset");

        for (int k = 0; k < 8; k++) begin
            logic [22:0] f1;
            logic [10:0] f2;
            logic [22:0] hold1;
            logic [10:0] hold2;
            f1 = {2'(k % 3), 5'(k * 4 + 1), 2'(k % 4), 1'(k), 2'(k >> 1), 1'(k >> 1), 1'(k >> 2),
                  3'(7 - k), 3'(k), 3'(k)};
            f2 = {5'(k * 4 + 3), 3'(k), 3'(7 - k)};
            hold2 = m_w2;
            // R1 R3: odd k adds junk leading bits
            if (k % 2 == 1) send({37'h0, 3'b101, f1, 1'b1}, 27);
            else            send({40'h0, f1, 1'b1}, 24);
            check_all("R1 R3 w1");
            check("R2", "w2 held", int'({demod_trim, comp_code, test_sel}), int'(hold2));
            hold1 = m_w1;
            if (k % 2 == 1) send({47'h0, 5'b11011, f2, 1'b0}, 17);
            else            send({52'h0, f2, 1'b0}, 12);
            check_all("R2 R3 w2");
            check("R2", "w1 held", int'(cp_code), int'(hold1[2:0]));
            check("R2", "w1 swallow held", int'(swallow_code), int'(hold1[20:16]));
        end

        // R9 empty frame
        send(64'h0, 0);
        check_all("R9 empty");

        // R10 stray clocks with strobe high, then a single-bit frame to word 1
        send({40'h0, 23'h5A5A5A, 1'b1}, 24);
        bus_data = 1'b1;
        for (int i = 0; i < 3; i++) begin
            wait_cyc(4); bus_clk = 1'b1; wait_cyc(4); bus_clk = 1'b0;
        end
        wait_cyc(8);
        send(64'h1, 1);
        check("R10", "carry word", int'({ref_code, swallow_code, main_code, vco_tx_sel}),
              int'(m_w1[22:13]));
        check_all("R10 R3 short");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule